// File: doc/BRIEF.md
# Indirect Event Counter Access Window

This block holds a bank of event counters that software cannot address one by one. Software first writes a counter index into a selector register. Every later read or write of a single 64-bit data window then goes to the counter that index names. Each counter also counts up by one in every cycle that its event increment input is high. A mode input sets the counter width for the whole bank: 64 bits or 32 bits.

Every window access is checked against two limits. The first is the number of counters that exist, which is fixed by a parameter. The second is an accessible-counter limit that a hypervisor-level field supplies. An index that names no counter gives an undefined response. When the hypervisor level is enabled, an index that names an existing counter at or above the accessible limit, used from one of the two lowest privilege levels, gives a trap response. In both cases the read returns zero and the write changes nothing. Read data and both flags are registered and appear in the cycle after the access.

Top module: `evcnt_window`

## Requirements
- R1: A selector write stores its 5-bit index from the next cycle onward. Window reads and writes always act on the counter named by the index stored before the access. After reset the stored index is 0.
- R2: When `wide_mode_i` is 1, a window write stores all 64 bits into the selected counter, and a window read returns all 64 bits of it.
- R3: When `wide_mode_i` is 0, a window read returns bits 63:32 as zero and bits 31:0 of the counter. A window write stores bits 31:0 and clears bits 63:32 of the counter.
- R4: An access whose stored index is at or above `NUM_CNT` raises `undef_o`, returns zero read data and changes no counter.
- R5: Take an access whose index is below `NUM_CNT`. If `hyp_en_i` is 1, `priv_lvl_i` is 0 or 1, and the index is at or above `acc_limit_i`, the access raises `trap_o`, returns zero read data and changes no counter. `undef_o` stays low.
- R6: No trap is raised when `hyp_en_i` is 0 or when `priv_lvl_i` is 2 or 3. In those cases the accessible range is the full implemented range.
- R7: Each cycle, every counter whose bit of `evt_inc_i` is 1 increases by one. In 32-bit mode the count wraps from 0xFFFFFFFF to 0 and bits 63:32 are cleared.
- R8: A window write and an event increment to the same counter in the same cycle leave the written value. The increment is lost.
- R9: Read data and flags are registered. They are valid in the cycle after the access. In a cycle after no window access they are all zero, and a write leaves the read data at zero.
- R10: During and after reset, `rd_data_o`, `undef_o` and `trap_o` are zero. Counter contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_wr_i | input | 1 | Write the selector register |
| sel_wdata_i | input | 5 | Counter index to store |
| win_rd_i | input | 1 | Read through the data window |
| win_wr_i | input | 1 | Write through the data window |
| win_wdata_i | input | 64 | Window write data |
| wide_mode_i | input | 1 | 1: 64-bit counters, 0: 32-bit counters |
| priv_lvl_i | input | 2 | Privilege level of the access (0 lowest, 3 highest) |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| acc_limit_i | input | 5 | Accessible-counter limit from the hypervisor level |
| evt_inc_i | input | NUM_CNT | Per-counter event increment |
| rd_data_o | output | 64 | Registered window read data |
| undef_o | output | 1 | Registered undefined-access flag |
| trap_o | output | 1 | Registered trap flag |

## Verification
All three outputs respond one clock edge after the access. A selector write or counter update made at the same edge is seen only by an access in a later cycle. The bench drives every input on the falling edge and compares the outputs on the next falling edge. It keeps a model of the selector and the counters and updates that model only after it has worked out the expected result from the old state. This mirrors the one-cycle lag of the selector and of the counter updates. Increments are modelled cycle by cycle in the same step, so the expected value of a counter is always the value before the edge at which it is read.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
    localparam int SEL_W  = 5;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {
        PRIV_APP  = 2'd0,
        PRIV_KERN = 2'd1,
        PRIV_HYP  = 2'd2,
        PRIV_MON  = 2'd3
    } priv_e;

    typedef struct packed {
        logic undef;
        logic trap;
        logic ok;
    } acc_res_t;
endpackage

// File: rtl/evcnt_access_check.sv
module evcnt_access_check
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input  logic             access_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             hyp_en_i,
    input  logic [1:0]       priv_lvl_i,
    input  logic [SEL_W-1:0] acc_limit_i,
    output acc_res_t         res_o
);
    localparam logic [SEL_W-1:0] IMPL_N = SEL_W'(NUM_CNT);

    logic low_priv;
    logic over_impl;
    logic over_acc;

    always_comb begin
        low_priv  = (priv_lvl_i == PRIV_APP) || (priv_lvl_i == PRIV_KERN);
        over_impl = (sel_i >= IMPL_N);
        over_acc  = hyp_en_i && low_priv && (sel_i >= acc_limit_i);

        res_o.undef = access_i && over_impl;
        res_o.trap  = access_i && !over_impl && over_acc;
        res_o.ok    = access_i && !over_impl && !over_acc;
    end
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter
    import evcnt_pkg::*;
(
    input  logic              clk_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              inc_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] cnt_o
);
    logic [DATA_W-1:0] cnt_d, cnt_q;
    logic [HALF_W-1:0] low_inc;

    always_comb begin
        low_inc = cnt_q[HALF_W-1:0] + HALF_W'(1);
        cnt_d   = cnt_q;
        if (wr_en_i) begin
            cnt_d = wide_i ? wdata_i : {{HALF_W{1'b0}}, wdata_i[HALF_W-1:0]};
        end else if (inc_i) begin
            cnt_d = wide_i ? (cnt_q + DATA_W'(1)) : {{HALF_W{1'b0}}, low_inc};
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/evcnt_window.sv
module evcnt_window
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sel_wr_i,
    input  logic [SEL_W-1:0]      sel_wdata_i,
    input  logic                  win_rd_i,
    input  logic                  win_wr_i,
    input  logic [DATA_W-1:0]     win_wdata_i,
    input  logic                  wide_mode_i,
    input  logic [1:0]            priv_lvl_i,
    input  logic                  hyp_en_i,
    input  logic [SEL_W-1:0]      acc_limit_i,
    input  logic [NUM_CNT-1:0]    evt_inc_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic                  undef_o,
    output logic                  trap_o
);
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] rd_data;
        logic              undef;
        logic              trap;
    } state_t;

    state_t            state_d, state_q;
    acc_res_t          acc_res;
    logic [DATA_W-1:0] cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0] cnt_wr;
    logic [DATA_W-1:0] sel_val;
    logic              access;

    assign access = win_rd_i || win_wr_i;

    evcnt_access_check #(.NUM_CNT(NUM_CNT)) u_check (
        .access_i    (access),
        .sel_i       (state_q.sel),
        .hyp_en_i    (hyp_en_i),
        .priv_lvl_i  (priv_lvl_i),
        .acc_limit_i (acc_limit_i),
        .res_o       (acc_res)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign cnt_wr[i] = win_wr_i && acc_res.ok && (state_q.sel == SEL_W'(i));

        evcnt_counter u_cnt (
            .clk_i   (clk_i),
            .wr_en_i (cnt_wr[i]),
            .wdata_i (win_wdata_i),
            .inc_i   (evt_inc_i[i]),
            .wide_i  (wide_mode_i),
            .cnt_o   (cnt_val[i])
        );
    end

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (state_q.sel == SEL_W'(i)) begin
                sel_val = cnt_val[i];
            end
        end
    end

    always_comb begin
        state_d         = state_q;
        state_d.undef   = acc_res.undef;
        state_d.trap    = acc_res.trap;
        state_d.rd_data = '0;
        if (win_rd_i && acc_res.ok) begin
            state_d.rd_data = wide_mode_i ? sel_val
                                          : {{HALF_W{1'b0}}, sel_val[HALF_W-1:0]};
        end
        if (sel_wr_i) begin
            state_d.sel = sel_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data_o = state_q.rd_data;
    assign undef_o   = state_q.undef;
    assign trap_o    = state_q.trap;
endmodule

// File: rtl/evcnt_window_chk.sv
module evcnt_window_chk
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              win_rd_i,
    input logic              win_wr_i,
    input logic              wide_mode_i,
    input logic [1:0]        priv_lvl_i,
    input logic              hyp_en_i,
    input logic [SEL_W-1:0]  acc_limit_i,
    input logic [SEL_W-1:0]  sel,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              undef_o,
    input logic              trap_o
);
    localparam logic [SEL_W-1:0] IMPL_N = SEL_W'(NUM_CNT);

    logic acc;
    assign acc = win_rd_i || win_wr_i;

    // R4
    undef_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && sel >= IMPL_N) |=> (undef_o && !trap_o));

    // R4
    undef_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        undef_o |-> (rd_data_o == '0));

    // R5
    trap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && sel < IMPL_N && hyp_en_i && priv_lvl_i < 2'd2 && sel >= acc_limit_i)
        |=> (trap_o && !undef_o && rd_data_o == '0));

    // R6
    no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && (!hyp_en_i || priv_lvl_i >= 2'd2)) |=> !trap_o);

    // R3
    narrow_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_rd_i && !wide_mode_i) |=> (rd_data_o[DATA_W-1:HALF_W] == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> (!undef_o && !trap_o && rd_data_o == '0));
endmodule

bind evcnt_window evcnt_window_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_rd_i    (win_rd_i),
    .win_wr_i    (win_wr_i),
    .wide_mode_i (wide_mode_i),
    .priv_lvl_i  (priv_lvl_i),
    .hyp_en_i    (hyp_en_i),
    .acc_limit_i (acc_limit_i),
    .sel         (state_q.sel),
    .rd_data_o   (rd_data_o),
    .undef_o     (undef_o),
    .trap_o      (trap_o)
);

// File: tb/evcnt_window_tb.sv
module evcnt_window_tb;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [4:0]  sel_wd = '0;
    logic        win_rd = 1'b0;
    logic        win_wr = 1'b0;
    logic [63:0] win_wd = '0;
    logic        wide = 1'b1;
    logic [1:0]  priv = 2'd3;
    logic        hyp = 1'b0;
    logic [4:0]  lim = 5'd31;
    logic [N-1:0] inc = '0;
    logic [63:0] rd_data;
    logic        undef_f;
    logic        trap_f;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] m_cnt [32];
    logic [4:0]  m_sel = '0;

    always #5 clk = ~clk;

    evcnt_window #(.NUM_CNT(N)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sel_wr_i(sel_wr), .sel_wdata_i(sel_wd),
        .win_rd_i(win_rd), .win_wr_i(win_wr), .win_wdata_i(win_wd),
        .wide_mode_i(wide), .priv_lvl_i(priv), .hyp_en_i(hyp),
        .acc_limit_i(lim), .evt_inc_i(inc), .rd_data_o(rd_data),
        .undef_o(undef_f), .trap_o(trap_f)
    );

    function automatic logic [63:0] view(input logic [63:0] v, input bit w);
        return w ? v : {32'h0, v[31:0]};
    endfunction

    function automatic logic [63:0] bumped(input logic [63:0] v, input bit w);
        return w ? v + 64'd1 : {32'h0, v[31:0] + 32'd1};
    endfunction

    task automatic check(input string tag, input logic [63:0] e_rd,
                         input bit e_un, input bit e_tr);
        n_chk++;
        if (rd_data !== e_rd || undef_f !== e_un || trap_f !== e_tr) begin
            n_fail++;
            $display("FAIL %s: rd=%h undef=%b trap=%b, expected rd=%h undef=%b trap=%b",
                     tag, rd_data, undef_f, trap_f, e_rd, e_un, e_tr);
        end
    endtask

    // One cycle: drive at a falling edge, predict from the old model state, compare one edge later.
    task automatic step(input bit sw, input logic [4:0] sv, input bit rd, input bit wr,
                        input logic [63:0] wd, input logic [N-1:0] ev, input string tag);
        bit acc, e_un, e_tr, ok;
        logic [63:0] e_rd;
        sel_wr = sw; sel_wd = sv; win_rd = rd; win_wr = wr; win_wd = wd; inc = ev;
        acc  = rd || wr;
        e_un = acc && (m_sel >= 5'(N));
        e_tr = acc && !e_un && hyp && (priv < 2'd2) && (m_sel >= lim);
        ok   = acc && !e_un && !e_tr;
        e_rd = (rd && ok) ? view(m_cnt[m_sel], wide) : 64'h0;
        for (int i = 0; i < N; i++) begin
            if (wr && ok && m_sel == 5'(i)) m_cnt[i] = wide ? wd : {32'h0, wd[31:0]};
            else if (ev[i]) m_cnt[i] = bumped(m_cnt[i], wide);
        end
        if (sw) m_sel = sv;
        @(negedge clk);
        check(tag, e_rd, e_un, e_tr);
        sel_wr = 0; win_rd = 0; win_wr = 0; inc = '0;
    endtask

    task automatic pick(input logic [4:0] s);
        step(1, s, 0, 0, 64'h0, '0, "R1");
    endtask

    task automatic put(input logic [63:0] d, input string tag);
        step(0, 5'd0, 0, 1, d, '0, tag);
    endtask

    task automatic get(input string tag);
        step(0, 5'd0, 1, 0, 64'h0, '0, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_cnt[i] = '0;
        repeat (3) @(negedge clk);
        check("R10", 64'h0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", 64'h0, 0, 0);

        // R10: index 0 after reset, R1 writes through it
        put(64'hA5A5_0000_1111_2222, "R10");
        for (int i = 0; i < N; i++) begin
            pick(5'(i));
            put({32'hC0DE_0000 + 32'(i), 32'h1000_0000 + 32'(i)}, "R2");
        end
        for (int i = 0; i < N; i++) begin
            pick(5'(i));
            get("R1");
        end
        pick(5'd0);
        get("R10");

        // R3 narrow read and narrow write
        wide = 0;
        pick(5'd3); get("R3");
        put(64'hFFFF_FFFF_8765_4321, "R3");
        wide = 1; get("R3");

        // R4 unimplemented index
        pick(5'(N)); get("R4");
        put(64'hDEAD_BEEF_DEAD_BEEF, "R4");
        pick(5'd31); put(64'h1, "R4"); get("R4");
        for (int i = 0; i < N; i++) begin
            pick(5'(i)); get("R4");
        end

        // R5 trap above accessible limit
        hyp = 1; lim = 5'd2;
        for (int p = 0; p < 2; p++) begin
            priv = 2'(p);
            pick(5'd3); get("R5"); put(64'h5555, "R5");
            pick(5'd2); get("R5");
            pick(5'd1); get("R5");
        end
        lim = 5'd0; pick(5'd0); get("R5");
        hyp = 0; pick(5'd3); get("R5");

        // R6 no trap without hypervisor level or at high privilege
        priv = 2'd0; lim = 5'd1; pick(5'(N - 1)); get("R6");
        hyp = 1; priv = 2'd2; get("R6"); priv = 2'd3; put(64'h77, "R6"); get("R6");
        hyp = 0;

        // R7 increments and 32-bit wrap
        pick(5'd2); put(64'h0000_0000_FFFF_FFFF, "R7");
        step(0, 0, 0, 0, 0, N'(4), "R7");
        get("R7");
        put(64'h0000_0000_FFFF_FFFF, "R7");
        wide = 0; step(0, 0, 0, 0, 0, N'(4), "R7");
        wide = 1; get("R7");
        repeat (5) step(0, 0, 0, 0, 0, {N{1'b1}}, "R7");
        for (int i = 0; i < N; i++) begin
            pick(5'(i)); get("R7");
        end

        // R8 write beats increment
        pick(5'd1);
        step(0, 0, 0, 1, 64'h1234_5678_9ABC_DEF0, N'(2), "R8");
        get("R8");

        // R9 idle and write cycles return zero
        step(0, 0, 0, 0, 0, '0, "R9");
        put(64'h42, "R9");

        // random mix
        for (int k = 0; k < 600; k++) begin
            wide = 1'($urandom);
            hyp  = 1'($urandom);
            priv = 2'($urandom);
            lim  = 5'($urandom_range(0, N + 1));
            step(1'($urandom_range(0, 3) == 0), 5'($urandom_range(0, N + 1)),
                 1'($urandom), 1'($urandom_range(0, 2) == 0),
                 {$urandom, $urandom}, N'($urandom & $urandom), "R1");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        #1500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule